// File: doc/BRIEF.md
# Host Bus DMA Arbitration Interface

This block controls the host side of a network coprocessor that attaches to a 68000-style asynchronous system bus. When an internal engine needs a DMA master cycle, the block requests the bus. It waits for the host's grant and then takes the bus. It enables the external address and control transceivers and drives the active-low address strobe for the transfer. When the transfer completes, it hands the bus back in a fixed order.

The block also drives the direction pin of the external data buffers. That pin depends on the kind of cycle in progress, a host-initiated slave (DIO) cycle or a DMA master cycle, and on which way the data moves. It rests high when the bus is idle.

Each byte lane carries its own odd-parity bit. The block generates that bit for outgoing bytes and checks it on incoming bytes, and it keeps a sticky error flag per lane. It also raises the host interrupt request. When the host acknowledges, the block places its interrupt vector on the data bus.

Top module: `hostbus_dma_ctrl`

## Requirements
- R1: In the idle state, `dma_start` high at a clock edge drives `bus_req_n` low after that edge. The transfer direction `dma_write` is captured at the same edge.
- R2: `bus_grant_n` passes through a two-flop synchronizer. `bus_own_n` falls at the third rising edge after grant goes low, and only while `bus_req_n` is already low.
- R3: `addr_strobe_n` falls one cycle after `bus_own_n` falls. It is low only while `bus_own_n` is low.
- R4: `dma_done` during the strobe phase starts the release. After the first edge the strobe goes high while ownership and request stay low. After the second edge ownership goes high. After the third edge the request goes high.
- R5: While the bus is owned, `data_dir` is 1 for a DMA write (`dma_write`=1, data leaves the device) and 0 for a DMA read.
- R6: While the bus is not owned and `dio_cycle` is 1, `data_dir` is 0 for a DIO write (`dio_write`=1, host writes into the device) and 1 for a DIO read.
- R7: With no DMA ownership and no DIO cycle, `data_dir` is 1.
- R8: `tx_par[i]` is the odd-parity bit of lane i, which is `bus_dout[8*i+7:8*i]`. The lane's eight bits plus the parity bit hold an odd number of ones.
- R9: When `rx_valid` is high and lane i of `rx_data` together with `rx_par[i]` holds an even number of ones, `par_err[i]` sets one edge later. It stays set until an `err_clear` pulse. A lane with correct parity leaves its flag unchanged.
- R10: An `irq_raise` pulse drives `irq_n` low after the next edge. It stays low until the host acknowledges.
- R11: `iack_n` is synchronized by two flops. At the third edge after `iack_n` goes low with a request pending, `vec_oe` rises and `irq_n` goes high. `bus_dout` then carries `irq_vector` in lane 0 and zeros above it. `vec_oe` falls at the third edge after `iack_n` returns high.
- R12: After reset, `bus_req_n`, `bus_own_n`, `addr_strobe_n`, `irq_n` and `data_dir` are 1, and `vec_oe` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_start | input | 1 | Internal request for a DMA master transfer |
| dma_write | input | 1 | Direction of that transfer, 1 = device to host memory |
| dma_done | input | 1 | Pulse ending the current DMA transfer |
| dio_cycle | input | 1 | A host slave (DIO) cycle is in progress |
| dio_write | input | 1 | 1 = the host writes into the device |
| bus_grant_n | input | 1 | Asynchronous active-low bus grant from the host |
| bus_req_n | output | 1 | Active-low bus request |
| bus_own_n | output | 1 | Active-low bus-owned transceiver enable |
| addr_strobe_n | output | 1 | Active-low address strobe, driven during DMA |
| data_dir | output | 1 | Data buffer direction, 1 = out of the device |
| tx_data | input | DW | Outgoing data from the internal engine |
| bus_dout | output | DW | Data placed on the bus (vector while acknowledging) |
| tx_par | output | LANES | Odd parity per lane of `bus_dout` |
| vec_oe | output | 1 | The interrupt vector is being driven |
| rx_data | input | DW | Incoming data sampled from the bus |
| rx_par | input | LANES | Incoming parity bits per lane |
| rx_valid | input | 1 | `rx_data` and `rx_par` are valid this cycle |
| err_clear | input | 1 | Clears all sticky parity flags |
| par_err | output | LANES | Sticky parity error flag per lane |
| irq_raise | input | 1 | Internal pulse that requests a host interrupt |
| iack_n | input | 1 | Asynchronous active-low interrupt acknowledge |
| irq_vector | input | VW | Vector returned on acknowledge |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check the signal nesting on every cycle: strobe inside ownership and ownership inside request. They also check the release order, in which the strobe rises before ownership and ownership rises before the request. On every cycle they also hold the resting level of the direction pin, check that the vector appears only after a pending interrupt, and check that a parity flag rises only on a valid received word. The bench scenarios cover the rest. They show the exact synchronizer latency on grant and acknowledge, and the direction value for each combination of cycle type and transfer direction. They show the parity bit values for given bytes and which lane takes the blame for a bad byte. They also show that the error flags stay sticky until cleared.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_REQ     = 3'd1,
      ST_OWN     = 3'd2,
      ST_STROBE  = 3'd3,
      ST_DROP_AS = 3'd4,
      ST_DROP_OW = 3'd5
   } arb_state_t;

   localparam int unsigned LANE_W = 8;

   function automatic logic odd_bit(input logic [LANE_W-1:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1,
   parameter logic [W-1:0] INIT  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_depth
      $error("hbd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
      end else begin
         chain[0] <= async_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hbd_lane_parity.sv
module hbd_lane_parity
   import hbd_pkg::*;
#(
   parameter int unsigned LANES = 2,
   localparam int unsigned DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    out_data,
   output logic [LANES-1:0] out_par,
   input  logic [DW-1:0]    in_data,
   input  logic [LANES-1:0] in_par,
   input  logic             in_valid,
   input  logic             clear,
   output logic [LANES-1:0] err_flag
);
   if (LANES < 1) begin : g_bad_lanes
      $error("hbd_lane_parity: LANES must be at least 1");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic lane_bad;
      assign out_par[g] = odd_bit(out_data[g*LANE_W +: LANE_W]);
      assign lane_bad   = ~(^{in_data[g*LANE_W +: LANE_W], in_par[g]});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   err_flag[g] <= 1'b0;
         else if (in_valid && lane_bad) err_flag[g] <= 1'b1;
         else if (clear)                err_flag[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/hbd_dma_fsm.sv
module hbd_dma_fsm
   import hbd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic write_dir,
   input  logic done,
   input  logic grant_s,
   input  logic dio_cycle,
   input  logic dio_write,
   output logic req_n,
   output logic own_n,
   output logic strobe_n,
   output logic dir
);
   arb_state_t state_q, state_d;
   logic       wr_q;
   logic       owning;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start)   state_d = ST_REQ;
         ST_REQ:     if (grant_s) state_d = ST_OWN;
         ST_OWN:                  state_d = ST_STROBE;
         ST_STROBE:  if (done)    state_d = ST_DROP_AS;
         ST_DROP_AS:              state_d = ST_DROP_OW;
         ST_DROP_OW:              state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b1;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) wr_q <= write_dir;
      end
   end

   assign owning   = (state_q == ST_OWN) || (state_q == ST_STROBE) || (state_q == ST_DROP_AS);
   assign req_n    = (state_q == ST_IDLE);
   assign own_n    = ~owning;
   assign strobe_n = (state_q != ST_STROBE);

   always_comb begin
      if (owning)         dir = wr_q;
      else if (dio_cycle) dir = ~dio_write;
      else                dir = 1'b1;
   end
endmodule

// File: rtl/hbd_irq_unit.sv
module hbd_irq_unit #(
   parameter int unsigned DW = 16,
   parameter int unsigned VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          raise,
   input  logic          ack_s,
   input  logic [VW-1:0] vector,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_out,
   output logic          irq_n,
   output logic          vec_oe
);
   if (VW > DW) begin : g_bad_vw
      $error("hbd_irq_unit: vector wider than data bus");
   end

   logic pend_q;
   logic oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         if (ack_s && pend_q) oe_q <= 1'b1;
         else if (!ack_s)     oe_q <= 1'b0;
         if (raise)                 pend_q <= 1'b1;
         else if (ack_s && pend_q)  pend_q <= 1'b0;
      end
   end

   assign irq_n    = ~pend_q;
   assign vec_oe   = oe_q;
   assign data_out = oe_q ? DW'(vector) : data_in;
endmodule

// File: rtl/hostbus_dma_ctrl.sv
module hostbus_dma_ctrl
   import hbd_pkg::*;
#(
   parameter int unsigned LANES       = 2,
   parameter int unsigned VW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DW         = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_start,
   input  logic             dma_write,
   input  logic             dma_done,
   input  logic             dio_cycle,
   input  logic             dio_write,
   input  logic             bus_grant_n,
   output logic             bus_req_n,
   output logic             bus_own_n,
   output logic             addr_strobe_n,
   output logic             data_dir,
   input  logic [DW-1:0]    tx_data,
   output logic [DW-1:0]    bus_dout,
   output logic [LANES-1:0] tx_par,
   output logic             vec_oe,
   input  logic [DW-1:0]    rx_data,
   input  logic [LANES-1:0] rx_par,
   input  logic             rx_valid,
   input  logic             err_clear,
   output logic [LANES-1:0] par_err,
   input  logic             irq_raise,
   input  logic             iack_n,
   input  logic [VW-1:0]    irq_vector,
   output logic             irq_n
);
   logic [1:0] async_pair;
   logic [1:0] sync_pair;
   logic       grant_s;
   logic       ack_s;

   assign async_pair = {iack_n, bus_grant_n};

   hbd_sync #(.STAGES(SYNC_STAGES), .W(2), .INIT(2'b11)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (async_pair),
      .sync_out (sync_pair)
   );

   assign grant_s = ~sync_pair[0];
   assign ack_s   = ~sync_pair[1];

   hbd_dma_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (dma_start),
      .write_dir (dma_write),
      .done      (dma_done),
      .grant_s   (grant_s),
      .dio_cycle (dio_cycle),
      .dio_write (dio_write),
      .req_n     (bus_req_n),
      .own_n     (bus_own_n),
      .strobe_n  (addr_strobe_n),
      .dir       (data_dir)
   );

   hbd_irq_unit #(.DW(DW), .VW(VW)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .raise    (irq_raise),
      .ack_s    (ack_s),
      .vector   (irq_vector),
      .data_in  (tx_data),
      .data_out (bus_dout),
      .irq_n    (irq_n),
      .vec_oe   (vec_oe)
   );

   hbd_lane_parity #(.LANES(LANES)) u_par (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_data (bus_dout),
      .out_par  (tx_par),
      .in_data  (rx_data),
      .in_par   (rx_par),
      .in_valid (rx_valid),
      .clear    (err_clear),
      .err_flag (par_err)
   );
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
   parameter int unsigned LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_req_n,
   input logic             bus_own_n,
   input logic             addr_strobe_n,
   input logic             data_dir,
   input logic             dio_cycle,
   input logic             rx_valid,
   input logic [LANES-1:0] par_err,
   input logic             vec_oe,
   input logic             irq_n
);
   assert_own_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_own_n |-> !bus_req_n);

   assert_own_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_own_n) |-> $past(!bus_req_n));

   assert_strobe_in_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_strobe_n |-> !bus_own_n);

   assert_strobe_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_own_n) |-> $past(addr_strobe_n));

   assert_own_before_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req_n) |-> $past(bus_own_n));

   assert_dir_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_own_n && !dio_cycle) |-> data_dir);

   assert_par_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(par_err & ~$past(par_err)) != 0) |-> $past(rx_valid));

   assert_vector_after_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_oe) |-> $past(!irq_n));
endmodule

bind hostbus_dma_ctrl hbd_checker #(.LANES(LANES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_req_n     (bus_req_n),
   .bus_own_n     (bus_own_n),
   .addr_strobe_n (addr_strobe_n),
   .data_dir      (data_dir),
   .dio_cycle     (dio_cycle),
   .rx_valid      (rx_valid),
   .par_err       (par_err),
   .vec_oe        (vec_oe),
   .irq_n         (irq_n)
);

// File: tb/hostbus_dma_ctrl_test.sv
module hostbus_dma_ctrl_test;
   localparam int LANES = 2;
   localparam int DW    = 16;
   localparam int VW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_start = 0, dma_write = 0, dma_done = 0;
   logic dio_cycle = 0, dio_write = 0;
   logic bus_grant_n = 1;
   logic bus_req_n, bus_own_n, addr_strobe_n, data_dir;
   logic [DW-1:0] tx_data = '0;
   logic [DW-1:0] bus_dout;
   logic [LANES-1:0] tx_par;
   logic vec_oe;
   logic [DW-1:0] rx_data = '0;
   logic [LANES-1:0] rx_par = '0;
   logic rx_valid = 0, err_clear = 0;
   logic [LANES-1:0] par_err;
   logic irq_raise = 0, iack_n = 1;
   logic [VW-1:0] irq_vector = 8'h4C;
   logic irq_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   hostbus_dma_ctrl #(.LANES(LANES), .VW(VW)) uut (.*);

   typedef struct packed { logic [15:0] data; logic [1:0] par; } pvec_t;
   localparam pvec_t PTAB [8] = '{
      '{16'h0000, 2'b11}, '{16'h0100, 2'b01}, '{16'hFF01, 2'b10},
      '{16'h7F80, 2'b00}, '{16'h0303, 2'b11}, '{16'hA5C3, 2'b11},
      '{16'h0107, 2'b00}, '{16'h8000, 2'b01}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   task automatic dma_run(input logic wr);
      dma_write = wr; dma_start = 1;
      step(1);
      dma_start = 0;
      chk("R1 req after start", bus_req_n, 0);
      chk("R7 dir while only requesting", data_dir, 1);
      bus_grant_n = 0;
      step(2);
      chk("R2 own not before sync", bus_own_n, 1);
      step(1);
      chk("R2 own after grant sync", bus_own_n, 0);
      chk("R3 strobe not with own", addr_strobe_n, 1);
      chk("R5 dma direction", data_dir, wr);
      step(1);
      chk("R3 strobe one cycle later", addr_strobe_n, 0);
      dma_done = 1;
      step(1);
      dma_done = 0;
      chk("R4 strobe released first", {addr_strobe_n, bus_own_n, bus_req_n}, 3'b100);
      step(1);
      chk("R4 own released second", {addr_strobe_n, bus_own_n, bus_req_n}, 3'b110);
      step(1);
      chk("R4 req released last", {addr_strobe_n, bus_own_n, bus_req_n}, 3'b111);
      chk("R7 dir back high", data_dir, 1);
      bus_grant_n = 1;
      step(3);
   endtask

   initial begin
      step(2);
      chk("R12 reset outputs", {bus_req_n, bus_own_n, addr_strobe_n, irq_n, data_dir, vec_oe}, 6'b111110);
      chk("R12 reset parity flags", par_err, 0);
      rst_n = 1;
      step(1);

      // R8/R9 vector table walk
      for (int i = 0; i < 8; i++) begin
         tx_data = PTAB[i].data;
         step(1);
         chk("R8 lane parity", tx_par, PTAB[i].par);
         rx_data = PTAB[i].data; rx_par = PTAB[i].par; rx_valid = 1;
         step(1);
         chk("R9 good parity no flag", par_err, 0);
         rx_par = PTAB[i].par ^ 2'b01;
         step(1);
         rx_valid = 0;
         chk("R9 lane0 flag only", par_err, 2'b01);
         rx_valid = 0; err_clear = 1;
         step(1);
         err_clear = 0;
         chk("R9 clear", par_err, 0);
      end

      // R9 sticky and lane 1 blame, bad data ignored without rx_valid
      rx_data = 16'h0100; rx_par = 2'b11;
      step(1);
      chk("R9 invalid word ignored", par_err, 0);
      rx_valid = 1;
      step(1);
      rx_valid = 0; rx_par = 2'b01;
      chk("R9 lane1 flag", par_err, 2'b10);
      step(3);
      chk("R9 flag sticky", par_err, 2'b10);
      err_clear = 1; step(1); err_clear = 0;
      chk("R9 cleared", par_err, 0);

      // R6 DIO directions
      dio_cycle = 1; dio_write = 1;
      step(1);
      chk("R6 dio write dir", data_dir, 0);
      dio_write = 0;
      step(1);
      chk("R6 dio read dir", data_dir, 1);
      dio_cycle = 0;
      step(1);
      chk("R7 idle dir", data_dir, 1);

      // R1-R5 DMA both directions
      dma_run(1'b1);
      dma_run(1'b0);

      // R5 ownership overrides a concurrent DIO indication
      dio_cycle = 1; dio_write = 0;
      dma_write = 0; dma_start = 1; step(1); dma_start = 0;
      bus_grant_n = 0; step(3);
      chk("R5 dma read dir wins over dio", data_dir, 0);
      dma_done = 1; step(1); dma_done = 0; step(2);
      bus_grant_n = 1; dio_cycle = 0; step(3);

      // R10/R11 interrupt handshake
      tx_data = 16'hFFFF;
      irq_raise = 1; step(1); irq_raise = 0;
      chk("R10 irq asserted", irq_n, 0);
      step(2);
      chk("R10 irq held", irq_n, 0);
      iack_n = 0;
      step(2);
      chk("R11 vector not before sync", vec_oe, 0);
      step(1);
      chk("R11 vector enable", vec_oe, 1);
      chk("R11 irq released", irq_n, 1);
      chk("R11 vector on bus", bus_dout, 16'h004C);
      chk("R8 vector parity", tx_par, 2'b10);
      iack_n = 1;
      step(2);
      chk("R11 vector held during sync", vec_oe, 1);
      step(1);
      chk("R11 vector dropped", vec_oe, 0);
      chk("R11 data back on bus", bus_dout, 16'hFFFF);

      summary();
   end
endmodule